// File: doc/BRIEF.md
# Symmetric-Node Binary-Tree Sharer Codec

This block compresses an exact list of sharer tiles into a short code and expands that code back into a destination mask. The tiles form the leaves of a binary tree. A code is a tree level together with a 2-bit selector. The level says how many low-order ID bits are don't-care. The selector picks a base node: the home ID with its two most significant bits replaced.

The encoder tries all four base nodes that differ from the home only in those top two bits. It keeps the base whose covering subtree is smallest. The result is registered one cycle after a valid input.

The decoder is purely combinational. It turns a home ID, a level and a selector into an N-bit mask. The mask may include nodes that are not sharers, but it never drops a real one. A directory stores the code and consults the decoder whenever it must reach the sharers.

Top module: `stsn_codec`

## Requirements
- R1: While reset is high, and after it, until the first valid input, `enc_valid_o` is 0, `enc_level_o` is 0 and `enc_sel_o` is 0.
- R2: `enc_valid_o` is high in exactly the cycle after a cycle in which `enc_valid_i` was high at a rising edge.
- R3: The level is the smallest L, over all four candidate bases, for which every set sharer bit j satisfies (j >> L) == (base >> L). The level never exceeds log2(N). The level field is ceil(log2(log2(N)+1)) bits wide, which is 3 bits for N=16.
- R4: The selector value s means base = home XOR (s << (log2(N)-2)), so selector 0 is the home itself. When candidates tie on level, the lowest selector wins.
- R5: An all-zero sharer vector encodes as level 0 with selector 0.
- R6: In a cycle with `enc_valid_i` low, the encoder outputs keep their previous values.
- R7: The decoder sets bit j of `dec_mask_o` exactly when (j XOR base) >> level is 0, where base is derived from the home and selector as in R4. It therefore sets exactly 2^level bits.
- R8: Decoding the encoder's output with the same home gives a mask that contains every bit of the original sharer vector.
- R9: With N=16, home 0 and sharers {1,4,5}, the code is level 3 with selector 0, and the decoded mask is 0x00FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Encode request |
| enc_home_i | input | log2(N) | Home node ID to encode against |
| enc_sharers_i | input | N | Exact sharer vector |
| enc_valid_o | output | 1 | Encoded result present |
| enc_level_o | output | ceil(log2(log2(N)+1)) | Tree level of the result |
| enc_sel_o | output | 2 | Symmetric-node selector of the result |
| dec_home_i | input | log2(N) | Home node ID for decoding |
| dec_level_i | input | ceil(log2(log2(N)+1)) | Tree level to expand |
| dec_sel_i | input | 2 | Selector to expand |
| dec_mask_o | output | N | Destination mask |

## Verification
An encode result is due exactly one rising edge after the request. The bench drives each request on a falling edge and samples the level, selector and valid flag on the next falling edge. It then holds the request low for one more cycle, so it can confirm that valid has dropped and that the result has held. The decoder carries no register, so its mask is sampled one nanosecond after its inputs change. For the round-trip checks, the encoder's registered output is fed into the decoder, and the mask is compared against the sharer vector that was applied.

// File: rtl/stsn_pkg.sv
package stsn_pkg;
    localparam int SEL_W    = 2;
    localparam int NUM_SYM  = 4;
    localparam int NODES_DEF = 16;

    typedef logic [SEL_W-1:0] sym_sel_t;

    // width of the tree-level field for a given node count
    function automatic int lvl_width(input int nodes);
        return $clog2($clog2(nodes) + 1);
    endfunction
endpackage

// File: rtl/stsn_cand_level.sv
// Minimal covering level for one symmetric candidate base.
module stsn_cand_level #(
    parameter int NODES = 16,
    parameter int SEL   = 0,
    localparam int IDW  = $clog2(NODES),
    localparam int LVW  = stsn_pkg::lvl_width(NODES)
) (
    input  logic [IDW-1:0]   home_i,
    input  logic [NODES-1:0] sharers_i,
    output logic [LVW-1:0]   level_o
);
    logic [IDW-1:0] base;
    logic [IDW-1:0] diff;

    assign base = home_i ^ (IDW'(SEL) << (IDW - 2));

    always_comb begin
        level_o = '0;
        diff    = '0;
        for (int j = 0; j < NODES; j++) begin
            if (sharers_i[j]) begin
                diff = IDW'(j) ^ base;
                for (int b = 0; b < IDW; b++) begin
                    if (diff[b] && (LVW'(b + 1) > level_o))
                        level_o = LVW'(b + 1);
                end
            end
        end
    end
endmodule

// File: rtl/stsn_pick.sv
// Chooses the smallest level among the candidates; a tie keeps the lower selector.
module stsn_pick #(
    parameter int LVW = 3
) (
    input  logic [LVW-1:0]        lvls_i [stsn_pkg::NUM_SYM],
    output logic [LVW-1:0]        level_o,
    output stsn_pkg::sym_sel_t    sel_o
);
    always_comb begin
        level_o = lvls_i[0];
        sel_o   = '0;
        for (int s = 1; s < stsn_pkg::NUM_SYM; s++) begin
            if (lvls_i[s] < level_o) begin
                level_o = lvls_i[s];
                sel_o   = stsn_pkg::sym_sel_t'(s);
            end
        end
    end
endmodule

// File: rtl/stsn_decoder.sv
// Expands home, level and selector into a destination mask.
module stsn_decoder #(
    parameter int NODES = 16,
    localparam int IDW  = $clog2(NODES),
    localparam int LVW  = stsn_pkg::lvl_width(NODES)
) (
    input  logic [IDW-1:0]        home_i,
    input  logic [LVW-1:0]        level_i,
    input  stsn_pkg::sym_sel_t    sel_i,
    output logic [NODES-1:0]      mask_o
);
    logic [IDW-1:0] base;

    assign base = home_i ^ (IDW'(sel_i) << (IDW - 2));

    for (genvar j = 0; j < NODES; j++) begin : g_node
        assign mask_o[j] = ((IDW'(j) ^ base) >> level_i) == '0;
    end

    // R7
    always_comb begin
        if (int'(level_i) <= IDW)
            mask_size_chk: assert ($countones(mask_o) == (1 << level_i));
    end
endmodule

// File: rtl/stsn_codec.sv
module stsn_codec #(
    parameter int NODES = stsn_pkg::NODES_DEF,
    localparam int IDW  = $clog2(NODES),
    localparam int LVW  = stsn_pkg::lvl_width(NODES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_valid_i,
    input  logic [IDW-1:0]    enc_home_i,
    input  logic [NODES-1:0]  enc_sharers_i,
    output logic              enc_valid_o,
    output logic [LVW-1:0]    enc_level_o,
    output logic [1:0]        enc_sel_o,
    input  logic [IDW-1:0]    dec_home_i,
    input  logic [LVW-1:0]    dec_level_i,
    input  logic [1:0]        dec_sel_i,
    output logic [NODES-1:0]  dec_mask_o
);
    import stsn_pkg::*;

    typedef struct packed {
        logic [LVW-1:0] level;
        sym_sel_t       sel;
    } code_t;

    logic [LVW-1:0] cand_lvl [NUM_SYM];
    code_t          nxt_code, code_q;
    logic           valid_q;

    for (genvar s = 0; s < NUM_SYM; s++) begin : g_cand
        stsn_cand_level #(.NODES(NODES), .SEL(s)) u_cand (
            .home_i    (enc_home_i),
            .sharers_i (enc_sharers_i),
            .level_o   (cand_lvl[s])
        );
    end

    stsn_pick #(.LVW(LVW)) u_pick (
        .lvls_i  (cand_lvl),
        .level_o (nxt_code.level),
        .sel_o   (nxt_code.sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            code_q  <= '0;
        end else begin
            valid_q <= enc_valid_i;
            if (enc_valid_i)
                code_q <= nxt_code;
        end
    end

    assign enc_valid_o = valid_q;
    assign enc_level_o = code_q.level;
    assign enc_sel_o   = code_q.sel;

    stsn_decoder #(.NODES(NODES)) u_dec (
        .home_i  (dec_home_i),
        .level_i (dec_level_i),
        .sel_i   (dec_sel_i),
        .mask_o  (dec_mask_o)
    );

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        enc_valid_i |=> enc_valid_o);
    // R2
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enc_valid_i |=> !enc_valid_o);
    // R6
    hold_code_chk: assert property (@(posedge clk) disable iff (rst)
        !enc_valid_i |=> ($stable(enc_level_o) && $stable(enc_sel_o)));
    // R5
    empty_code_chk: assert property (@(posedge clk) disable iff (rst)
        (enc_valid_i && enc_sharers_i == '0) |=> (enc_level_o == '0 && enc_sel_o == '0));
    // R3
    level_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(enc_level_o) <= IDW);
endmodule

// File: tb/tb_stsn_codec.sv
`timescale 1ns/1ps
module tb_stsn_codec;
    localparam int N   = 16;
    localparam int IDW = $clog2(N);
    localparam int LVW = $clog2(IDW + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enc_valid_i = 1'b0;
    logic [IDW-1:0] enc_home_i = '0;
    logic [N-1:0] enc_sharers_i = '0;
    logic enc_valid_o;
    logic [LVW-1:0] enc_level_o;
    logic [1:0] enc_sel_o;
    logic [IDW-1:0] dec_home_i = '0;
    logic [LVW-1:0] dec_level_i = '0;
    logic [1:0] dec_sel_i = '0;
    logic [N-1:0] dec_mask_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    stsn_codec #(.NODES(N)) dut (
        .clk(clk), .rst(rst),
        .enc_valid_i(enc_valid_i), .enc_home_i(enc_home_i), .enc_sharers_i(enc_sharers_i),
        .enc_valid_o(enc_valid_o), .enc_level_o(enc_level_o), .enc_sel_o(enc_sel_o),
        .dec_home_i(dec_home_i), .dec_level_i(dec_level_i), .dec_sel_i(dec_sel_i),
        .dec_mask_o(dec_mask_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // reference: brute-force search over selectors and levels
    function automatic void ref_encode(input logic [IDW-1:0] home, input logic [N-1:0] sh,
                                       output int lvl, output int sel);
        lvl = IDW + 1;
        sel = 0;
        for (int s = 0; s < 4; s++) begin
            int base = int'(home) ^ (s << (IDW - 2));
            for (int l = 0; l <= IDW; l++) begin
                bit ok = 1'b1;
                for (int j = 0; j < N; j++)
                    if (sh[j] && ((j >> l) != (base >> l))) ok = 1'b0;
                if (ok) begin
                    if (l < lvl) begin lvl = l; sel = s; end
                    break;
                end
            end
        end
    endfunction

    function automatic logic [N-1:0] ref_mask(input int home, input int lvl, input int sel);
        int base = home ^ (sel << (IDW - 2));
        ref_mask = '0;
        for (int j = 0; j < N; j++)
            if ((j >> lvl) == (base >> lvl)) ref_mask[j] = 1'b1;
    endfunction

    // one encode: request on a falling edge, result one edge later
    task automatic do_encode(input int home, input logic [N-1:0] sh, input string req);
        int el, es;
        ref_encode(IDW'(home), sh, el, es);
        @(negedge clk);
        enc_home_i = IDW'(home); enc_sharers_i = sh; enc_valid_i = 1'b1;
        @(negedge clk);
        enc_valid_i = 1'b0;
        chk(enc_valid_o == 1'b1, {req, " valid"}, enc_valid_o, 1);
        chk(int'(enc_level_o) == el, {req, " level"}, enc_level_o, el);
        chk(int'(enc_sel_o) == es, {req, " sel"}, enc_sel_o, es);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        // R1
        chk(enc_valid_o == 0 && enc_level_o == 0 && enc_sel_o == 0, "R1 reset state",
            {enc_valid_o, enc_level_o, enc_sel_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(enc_valid_o == 0 && enc_level_o == 0, "R1 after reset", enc_valid_o, 0);
    endtask

    task automatic t_example();
        // R9: home 0, sharers {1,4,5}
        do_encode(0, 16'h0032, "R9 example");
        chk(enc_level_o == 3 && enc_sel_o == 0, "R9 code", {enc_level_o, enc_sel_o}, 3 << 2);
        dec_home_i = 0; dec_level_i = 3; dec_sel_i = 0;
        #1;
        chk(dec_mask_o == 16'h00FF, "R9 mask", dec_mask_o, 16'h00FF);
    endtask

    task automatic t_symmetric();
        // R3/R4: home 0, sharers {12,13} -> selector 3, level 1
        do_encode(0, 16'h3000, "R3 far pair");
        chk(enc_level_o == 1 && enc_sel_o == 3, "R4 far pair", {enc_level_o, enc_sel_o}, 7);
        // home 5, sharer {9} -> base 9, selector 3, level 0
        do_encode(5, 16'h0200, "R4 relative sel");
        chk(enc_level_o == 0 && enc_sel_o == 3, "R4 relative", {enc_level_o, enc_sel_o}, 3);
    endtask

    task automatic t_tie();
        // R4: home 0, sharers {0,4} tie at level 3 between selectors 0 and 1
        do_encode(0, 16'h0011, "R4 tie");
        chk(enc_sel_o == 0, "R4 tie lowest", enc_sel_o, 0);
    endtask

    task automatic t_empty_full();
        do_encode(6, '0, "R5 empty");
        chk(enc_level_o == 0 && enc_sel_o == 0, "R5 empty code", {enc_level_o, enc_sel_o}, 0);
        do_encode(6, 16'h0040, "R3 self only");
        do_encode(9, '1, "R3 all sharers");
        chk(enc_level_o == IDW, "R3 max level", enc_level_o, IDW);
    endtask

    task automatic t_hold();
        do_encode(2, 16'h000C, "R6 setup");
        // request low, inputs change: code and valid must not move (R6, R2)
        enc_home_i = 4'hF; enc_sharers_i = 16'h8001;
        @(negedge clk);
        chk(enc_valid_o == 0, "R2 valid drops", enc_valid_o, 0);
        chk(enc_level_o == 1 && enc_sel_o == 0, "R6 hold", {enc_level_o, enc_sel_o}, 4);
    endtask

    task automatic t_decoder();
        // R7: sweep every level and selector for a few homes
        foreach (dec_home_i[k]) ;
        for (int h = 0; h < N; h += 5) begin
            for (int l = 0; l <= IDW; l++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [N-1:0] em = ref_mask(h, l, s);
                    dec_home_i = IDW'(h); dec_level_i = LVW'(l); dec_sel_i = 2'(s);
                    #1;
                    chk(dec_mask_o == em, "R7 decode", dec_mask_o, em);
                end
            end
        end
    endtask

    task automatic t_roundtrip();
        // R8: random vectors, sparse and dense
        for (int i = 0; i < 200; i++) begin
            int h = $urandom_range(N - 1);
            logic [N-1:0] sh = N'($urandom);
            if (i % 2 == 0) sh = sh & N'($urandom) & N'($urandom);
            do_encode(h, sh, "R3 random");
            dec_home_i = IDW'(h); dec_level_i = enc_level_o; dec_sel_i = enc_sel_o;
            #1;
            chk((dec_mask_o & sh) == sh, "R8 superset", dec_mask_o, sh);
        end
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_example();
        t_symmetric();
        t_tie();
        t_empty_full();
        t_hold();
        t_decoder();
        t_roundtrip();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule